// File: doc/BRIEF.md
# Watchdog Reset Controller

This block resets the system when firmware stops servicing it. A small counter advances once per millisecond tick from an external free-running timer. Firmware keeps the system alive by writing any value to the restart register. If eight ticks pass with no restart write, the counter's top bit rises. The block then drives a reset pulse that lasts eight ticks. At the same time it sets a sticky status flag and gives a one-cycle strobe that clears the USB device address.

The USB transmitter enable stays low from the start of the reset until firmware writes the status flag back to 0. The reset pulse ending does not re-enable it. This keeps a device with a cleared address from answering traffic sent to address 0. While the suspend input is high, every tick is ignored. The watchdog count and the reset duration both freeze.

The register bus is a plain write strobe with an address and data. The read data is combinational from the address. The restart register sits at address 0x21 and reads as 0. The status register sits at address 0x1F, and bit 6 holds the watchdog flag. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `wdt_reset_ctrl`

## Requirements
- R1: While the reset input is low and after its release, `wdt_rst_o` and `addr_clr_o` are 0, `tx_en_o` is 1, and a read of address 0x1F returns 0x00.
- R2: After the counter has been cleared, the 8th accepted tick with no restart write in between raises `wdt_rst_o` in the cycle after that tick is sampled. The 7th such tick does not raise it.
- R3: A write of any data value to address 0x21 clears the watchdog count, so eight further ticks are needed before a reset. A read of address 0x21 returns 0x00.
- R4: Once raised, `wdt_rst_o` stays high for exactly 8 accepted ticks. It falls in the cycle after the 8th of them is sampled.
- R5: While `wdt_rst_o` is high, the watchdog count is held at zero, and ticks and restart writes do not advance it. After the pulse ends, eight new ticks are needed for the next reset.
- R6: When a watchdog reset starts, bit 6 of the status register at 0x1F is set. It stays set until a write to 0x1F with bit 6 equal to 0. A write with bit 6 equal to 1 leaves it unchanged. If a reset start and a clearing write fall in the same cycle, the bit ends up set.
- R7: `addr_clr_o` is high for exactly one cycle, in the first cycle that `wdt_rst_o` is high.
- R8: `tx_en_o` is 0 whenever `wdt_rst_o` is high or the status flag is set. Otherwise it is 1.
- R9: While `suspend_i` is high, ticks are ignored. Neither the watchdog count nor the reset duration advances.
- R10: A write to any address other than 0x21 does not affect the watchdog count.
- R11: If a restart write and a tick are sampled in the same cycle, the restart wins and the count is zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle millisecond tick from the free-running timer |
| suspend_i | input | 1 | Low-power hold; tick counting frozen while high |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for the current address |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| addr_clr_o | output | 1 | One-cycle strobe that clears the USB device address |
| tx_en_o | output | 1 | USB transmitter enable |

## Verification
The bench targets the tick count boundaries: seven ticks must not fire and the eighth must. The pulse must last exactly eight ticks. A design off by one would fire early, or give a pulse one tick long or short. A restart write that coincides with a tick must still clear the count. A design that let the increment win would reset one tick early. Restart writes and ticks during the pulse must not carry a count past it. Writes with bit 6 set must not clear the flag. A design that re-enabled the transmitter when the pulse ended would show `tx_en_o` high too early. Long random runs with suspend windows and stray addresses are checked cycle by cycle against a reference model.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int          WDT_CNT_W      = 4;
  localparam int          WDT_DUR_TICKS  = 8;
  localparam int          WDT_AW         = 8;
  localparam int          WDT_DW         = 8;
  localparam logic [7:0]  WDT_RESTART_AD = 8'h21;
  localparam logic [7:0]  WDT_STATUS_AD  = 8'h1F;
  localparam int          WDT_FLAG_BIT   = 6;

  typedef struct packed {
    logic restart;
    logic flag_clr;
  } wdt_cmd_t;
endpackage

// File: rtl/wdt_regif.sv
`timescale 1ns/1ps
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int            AW         = WDT_AW,
  parameter int            DW         = WDT_DW,
  parameter logic [AW-1:0] RESTART_AD = AW'(WDT_RESTART_AD),
  parameter logic [AW-1:0] STATUS_AD  = AW'(WDT_STATUS_AD),
  parameter int            FLAG_BIT   = WDT_FLAG_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          set_flag_i,
  output wdt_cmd_t      cmd_o,
  output logic          flag_o,
  output logic [DW-1:0] rdata_o
);
  logic flag_q, flag_d;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    cmd_o.restart  = we_i && (addr_i == RESTART_AD);
    cmd_o.flag_clr = we_i && (addr_i == STATUS_AD) && !wdata_i[FLAG_BIT];
  end

  always_comb begin
    flag_d = flag_q;
    if (set_flag_i)          flag_d = 1'b1;
    else if (cmd_o.flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == STATUS_AD) rdata_o[FLAG_BIT] = flag_q;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = WDT_CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en_i,
  input  logic restart_i,
  input  logic hold_i,
  output logic expire_o
);
  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    expire_o = 1'b0;
    cnt_d    = cnt_q;
    if (hold_i || restart_i) begin
      cnt_d = '0;
    end else if (tick_en_i) begin
      if (!cnt_q[MSB] && cnt_inc[MSB]) begin
        expire_o = 1'b1;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_pulse.sv
`timescale 1ns/1ps
module wdt_pulse
  import wdt_pkg::*;
#(
  parameter int DUR_TICKS = WDT_DUR_TICKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_en_i,
  output logic active_o,
  output logic strobe_o
);
  localparam int DUR_W = (DUR_TICKS > 1) ? $clog2(DUR_TICKS) : 1;
  localparam logic [DUR_W-1:0] DUR_LAST = DUR_W'(DUR_TICKS - 1);

  logic             act_q, act_d;
  logic             stb_q;
  logic [DUR_W-1:0] dur_q, dur_d;

  always_comb begin
    act_d = act_q;
    dur_d = dur_q;
    if (start_i) begin
      act_d = 1'b1;
      dur_d = '0;
    end else if (act_q && tick_en_i) begin
      if (dur_q == DUR_LAST) begin
        act_d = 1'b0;
        dur_d = '0;
      end else begin
        dur_d = dur_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      dur_q <= '0;
      stb_q <= 1'b0;
    end else begin
      act_q <= act_d;
      dur_q <= dur_d;
      stb_q <= start_i;
    end
  end

  assign active_o = act_q;
  assign strobe_o = stb_q;
endmodule

// File: rtl/wdt_reset_ctrl.sv
`timescale 1ns/1ps
module wdt_reset_ctrl
  import wdt_pkg::*;
#(
  parameter int            CNT_W      = WDT_CNT_W,
  parameter int            DUR_TICKS  = WDT_DUR_TICKS,
  parameter int            AW         = WDT_AW,
  parameter int            DW         = WDT_DW,
  parameter logic [AW-1:0] RESTART_AD = AW'(WDT_RESTART_AD),
  parameter logic [AW-1:0] STATUS_AD  = AW'(WDT_STATUS_AD),
  parameter int            FLAG_BIT   = WDT_FLAG_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          suspend_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          wdt_rst_o,
  output logic          addr_clr_o,
  output logic          tx_en_o
);
  logic     rst_meta, rst_n_s;
  logic     tick_en, expire, active, flag;
  wdt_cmd_t cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  assign tick_en = tick_i && !suspend_i;

  wdt_regif #(
    .AW(AW), .DW(DW), .RESTART_AD(RESTART_AD),
    .STATUS_AD(STATUS_AD), .FLAG_BIT(FLAG_BIT)
  ) u_regif (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .set_flag_i (expire),
    .cmd_o      (cmd),
    .flag_o     (flag),
    .rdata_o    (bus_rdata_o)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_en_i (tick_en),
    .restart_i (cmd.restart),
    .hold_i    (active),
    .expire_o  (expire)
  );

  wdt_pulse #(.DUR_TICKS(DUR_TICKS)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_i   (expire),
    .tick_en_i (tick_en),
    .active_o  (active),
    .strobe_o  (addr_clr_o)
  );

  assign wdt_rst_o = active;
  assign tx_en_o   = !flag && !active;
endmodule

// File: rtl/wdt_reset_ctrl_chk.sv
`timescale 1ns/1ps
module wdt_reset_ctrl_chk #(
  parameter int         DUR_TICKS  = 8,
  parameter logic [7:0] RESTART_AD = 8'h21,
  parameter logic [7:0] STATUS_AD  = 8'h1F,
  parameter int         FLAG_BIT   = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       suspend_i,
  input logic       bus_we_i,
  input logic [7:0] bus_addr_i,
  input logic [7:0] bus_wdata_i,
  input logic       wdt_rst_o,
  input logic       addr_clr_o,
  input logic       tx_en_o,
  input logic       flag
);
  localparam int CW = $clog2(DUR_TICKS + 1) + 1;
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             seen_q <= '0;
    else if (!wdt_rst_o)                    seen_q <= '0;
    else if (tick_i && !suspend_i)          seen_q <= seen_q + 1'b1;
  end

  p_dur_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= CW'(DUR_TICKS));

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clr_o |=> !addr_clr_o);

  p_strobe_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> addr_clr_o);

  p_tx_off_in_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> !tx_en_o);

  p_tx_off_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> !tx_en_o);

  p_flag_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> flag);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(bus_we_i && bus_addr_i == STATUS_AD && !bus_wdata_i[FLAG_BIT]))
      |=> flag);

  p_suspend_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_i |=> $stable(wdt_rst_o));

  p_restart_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_i && bus_addr_i == RESTART_AD) |=> !$rose(wdt_rst_o));
endmodule

bind wdt_reset_ctrl wdt_reset_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .tick_i      (tick_i),
  .suspend_i   (suspend_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .wdt_rst_o   (wdt_rst_o),
  .addr_clr_o  (addr_clr_o),
  .tx_en_o     (tx_en_o),
  .flag        (flag)
);

// File: tb/wdt_reset_ctrl_tb.sv
`timescale 1ns/1ps
module wdt_reset_ctrl_tb;
  localparam logic [7:0] RA = 8'h21;
  localparam logic [7:0] SA = 8'h1F;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i, suspend_i, bus_we_i;
  logic [7:0] bus_addr_i, bus_wdata_i, bus_rdata_o;
  logic       wdt_rst_o, addr_clr_o, tx_en_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  int m_cnt, m_dur;
  bit m_rst, m_flag, m_stb;

  always #2.5 clk = ~clk;

  wdt_reset_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .suspend_i(suspend_i),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .wdt_rst_o(wdt_rst_o),
    .addr_clr_o(addr_clr_o), .tx_en_o(tx_en_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata(input logic [7:0] a);
    return (a == SA) ? {1'b0, m_flag, 6'b0} : 8'h00;
  endfunction

  task automatic model_update();
    bit tk, rs, clr, exp_now;
    tk  = tick_i && !suspend_i;
    rs  = bus_we_i && bus_addr_i == RA;
    clr = bus_we_i && bus_addr_i == SA && !bus_wdata_i[6];
    exp_now = 1'b0;
    if (m_rst) begin
      m_cnt = 0;
      if (tk) begin
        if (m_dur == 7) begin m_rst = 1'b0; m_dur = 0; end
        else m_dur++;
      end
    end else if (rs) begin
      m_cnt = 0;
    end else if (tk) begin
      if (m_cnt == 7) begin exp_now = 1'b1; m_cnt = 0; end
      else m_cnt++;
    end
    if (exp_now) begin m_rst = 1'b1; m_dur = 0; end
    m_stb = exp_now;
    if (exp_now) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
  endtask

  task automatic step(input bit tk, input bit sus, input bit we,
                      input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tick_i = tk; suspend_i = sus; bus_we_i = we; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk);
    model_update();
    #1;
    chk("R2 R4 wdt_rst_o", {7'b0, wdt_rst_o}, {7'b0, m_rst});
    chk("R7 addr_clr_o", {7'b0, addr_clr_o}, {7'b0, m_stb});
    chk("R8 tx_en_o", {7'b0, tx_en_o}, {7'b0, !m_flag && !m_rst});
    chk("R6 R3 rdata", bus_rdata_o, exp_rdata(a));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
      step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b0, 1'b0, 1'b1, a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; tick_i = 0; suspend_i = 0; bus_we_i = 0;
    bus_addr_i = SA; bus_wdata_i = 0;
    m_cnt = 0; m_dur = 0; m_rst = 0; m_flag = 0; m_stb = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rst in reset", {7'b0, wdt_rst_o}, 8'h00);
    chk("R1 tx_en in reset", {7'b0, tx_en_o}, 8'h01);
    chk("R1 addr_clr in reset", {7'b0, addr_clr_o}, 8'h00);
    chk("R1 status in reset", bus_rdata_o, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 1'b0, SA, 8'h00);
    chk("R1 status after release", bus_rdata_o, 8'h00);

    // R2: seven ticks quiet, eighth fires
    ticks(7);
    chk("R2 no reset after 7", {7'b0, wdt_rst_o}, 8'h00);
    step(1'b1, 1'b0, 1'b0, SA, 8'h00);
    chk("R2 reset after 8", {7'b0, wdt_rst_o}, 8'h01);
    chk("R7 strobe at start", {7'b0, addr_clr_o}, 8'h01);
    chk("R6 flag set", bus_rdata_o, 8'h40);
    step(1'b0, 1'b0, 1'b0, SA, 8'h00);
    chk("R7 strobe one cycle", {7'b0, addr_clr_o}, 8'h00);

    // R4/R5: restart writes and ticks during pulse; duration exact
    wr(RA, 8'h5A);
    ticks(7);
    chk("R4 still high after 7", {7'b0, wdt_rst_o}, 8'h01);
    step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    chk("R4 low after 8", {7'b0, wdt_rst_o}, 8'h00);
    chk("R8 tx still off after pulse", {7'b0, tx_en_o}, 8'h00);
    ticks(7);
    chk("R5 fresh count after pulse", {7'b0, wdt_rst_o}, 8'h00);
    wr(RA, 8'h00);

    // R6/R8: bit6=1 write keeps flag, bit6=0 write clears it
    wr(SA, 8'hFF);
    chk("R6 write 1 keeps flag", bus_rdata_o, 8'h40);
    chk("R8 tx off with flag", {7'b0, tx_en_o}, 8'h00);
    wr(SA, 8'hBF);
    chk("R6 write 0 clears flag", bus_rdata_o, 8'h00);
    chk("R8 tx back on", {7'b0, tx_en_o}, 8'h01);

    // R9: suspend freezes counting
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    chk("R9 no reset while suspended", {7'b0, wdt_rst_o}, 8'h00);
    wr(RA, 8'h01);

    // R10: foreign address write does not clear
    ticks(4);
    wr(8'h20, 8'hFF);
    wr(8'h22, 8'h00);
    ticks(3);
    chk("R10 not yet", {7'b0, wdt_rst_o}, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    chk("R10 foreign writes ignored", {7'b0, wdt_rst_o}, 8'h01);
    ticks(8);
    wr(SA, 8'h00);
    chk("R3 restart reads zero", 8'h00, exp_rdata(RA));

    // R11: restart beats a coincident tick
    ticks(7);
    step(1'b1, 1'b0, 1'b1, RA, 8'hC3);
    chk("R11 restart wins", {7'b0, wdt_rst_o}, 8'h00);
    ticks(7);
    chk("R11 count restarted", {7'b0, wdt_rst_o}, 8'h00);
    step(1'b1, 1'b0, 1'b0, RA, 8'h00);
    chk("R3 restart read", bus_rdata_o, 8'h00);
    chk("R3 eighth after restart fires", {7'b0, wdt_rst_o}, 8'h01);
    ticks(8);
    wr(SA, 8'h00);

    // random phase against reference model
    for (int i = 0; i < 6000; i++) begin
      bit tk, sus, we;
      logic [7:0] a;
      int r;
      tk  = ($urandom % 3) == 0;
      sus = ($urandom % 40) < 3;
      r   = $urandom % 40;
      we  = r < 4;
      a   = (r < 2) ? RA : (r < 3) ? SA : 8'($urandom);
      if (!we && ($urandom % 2)) a = SA;
      step(tk, sus, we, a, 8'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule